// File: doc/BRIEF.md
# Digit Word Serial Formatter

This block takes the multiplexed decimal output of a dual-slope converter and sends it to a remote receiver as five serial words per measurement. Each capture pulse marks the middle of one digit-drive window. On that pulse the block samples the one-hot digit drive and the four-bit BCD value. It packs them into an 8-bit word: the upper nibble identifies the digit, and the lower nibble carries the data. It then shifts the word out as an asynchronous frame with a parity bit.

The most significant digit can only be 0 or 1. Its three unused BCD bits are therefore replaced with the sign, overrange and underrange flags. Parity is either fixed (even or odd) or driven by the sign of the reading, so that a receiver can recover polarity from its parity check. The parity choice is taken when the most significant word is loaded and is kept for the rest of the burst. A capture pulse that arrives while a frame is still being sent is refused, and a sticky error flag records it.

Top module: `dws_top`

## Requirements
- R1: After reset, `txd_o` is 1, `busy_o` is 0 and `err_o` is 0, and `txd_o` stays 1 whenever `busy_o` is 0.
- R2: A capture pulse accepted at clock edge E drives `txd_o` through 11 bit slots of `BAUD_DIV` clocks each. Slot k occupies the edges from E+k*BAUD_DIV up to E+(k+1)*BAUD_DIV. The slots are a start bit of 0, the eight word bits least significant first, the parity bit, and a stop bit of 1.
- R3: The upper nibble (word bits 7..4) identifies the digit. `digit_i` bit k drives digit k+1. Digit 5 (`digit_i[4]`) gives 0000, digit 4 gives 1000, digit 3 gives 0100, digit 2 gives 0010 and digit 1 gives 0001, written with bit 7 first.
- R4: For digits 1 to 4, word bits 3..0 equal `bcd_i`.
- R5: For digit 5, word bit 3 is `pos_i` (1 = positive), bit 2 is `ovr_i`, bit 1 is `und_i` and bit 0 is `bcd_i[0]`. `bcd_i[3:1]` has no effect on the frame.
- R6: With `par_sign_i`=0, the parity bit makes the nine word-plus-parity bits even in count of ones when `par_odd_i`=0, and odd when `par_odd_i`=1.
- R7: With `par_sign_i`=1, parity is even for a positive reading and odd for a negative one.
- R8: `par_sign_i`, `par_odd_i` and the sign that sets parity are sampled on the digit-5 capture. Later words use those sampled values even if the inputs have changed.
- R9: A capture pulse while `busy_o` is 1 leaves the frame in progress unchanged, starts no new frame, and sets `err_o`, which stays 1 until reset.
- R10: `busy_o` is 1 from edge E until edge E+11*BAUD_DIV, where it returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Capture pulse, one clock wide |
| digit_i | input | 5 | One-hot digit drive, bit 4 = most significant digit |
| bcd_i | input | 4 | BCD value of the driven digit |
| pos_i | input | 1 | Reading sign, 1 = positive |
| ovr_i | input | 1 | Overrange flag |
| und_i | input | 1 | Underrange flag |
| par_sign_i | input | 1 | 1 = parity follows sign |
| par_odd_i | input | 1 | Fixed parity select when par_sign_i = 0 |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |
| err_o | output | 1 | Sticky refused-capture flag |

## Verification
Two situations are hard to reach from the ports. The first is a capture pulse that lands in the middle of a frame. The bench raises the strobe a few bit slots into a frame, with different digit data on the inputs. It then checks that the frame still decodes to the original word, that no extra frame follows, and that the error flag stays set through later clean frames. The second is the held parity choice. Digit-4 to digit-1 words are sent after the parity and sign inputs have been flipped, and their parity is checked against the values sampled on the preceding digit-5 word.

// File: rtl/dws_pkg.sv
package dws_pkg;
  localparam int NUM_DIGITS = 5;
  localparam int WORD_W     = 8;
  localparam int FRAME_BITS = WORD_W + 3;

  typedef struct packed {
    logic sign_mode;
    logic fixed_odd;
    logic pos;
  } par_cfg_t;
endpackage

// File: rtl/dws_word_pack.sv
module dws_word_pack
  import dws_pkg::*;
(
  input  logic [NUM_DIGITS-1:0] digit,
  input  logic [3:0]            bcd,
  input  logic                  pos,
  input  logic                  ovr,
  input  logic                  und,
  output logic [WORD_W-1:0]     word
);
  localparam int ID_W = NUM_DIGITS - 1;

  logic [ID_W-1:0] id_nib;
  logic [3:0]      data_nib;

  // digit k+1 (k < NUM_DIGITS-1) owns bit k of the id nibble; the top digit is all zero
  genvar g;
  generate
    for (g = 0; g < ID_W; g++) begin : g_id
      assign id_nib[g] = digit[g];
    end
  endgenerate

  always_comb begin
    if (digit[NUM_DIGITS-1]) data_nib = {pos, ovr, und, bcd[0]};
    else                     data_nib = bcd;
  end

  assign word = {id_nib, data_nib};
endmodule

// File: rtl/dws_par_cfg.sv
module dws_par_cfg
  import dws_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  logic     is_msd,
  input  par_cfg_t cfg_in,
  output logic     odd_sel
);
  par_cfg_t held_q;
  par_cfg_t eff;

  always_ff @(posedge clk) begin
    if (rst)                  held_q <= '0;
    else if (load && is_msd)  held_q <= cfg_in;
  end

  // the first word of a burst uses the live setting, later words the held one
  assign eff     = is_msd ? cfg_in : held_q;
  assign odd_sel = eff.sign_mode ? ~eff.pos : eff.fixed_odd;
endmodule

// File: rtl/dws_uart_tx.sv
module dws_uart_tx
  import dws_pkg::*;
#(
  parameter int BAUD_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              par_bit,
  output logic              txd,
  output logic              busy
);
  localparam int CW = $clog2(BAUD_DIV + 1);
  localparam int LW = $clog2(FRAME_BITS + 1);

  logic [CW-1:0]           baud_q;
  logic [LW-1:0]           left_q;
  logic [FRAME_BITS-2:0]   sh_q;
  logic                    end_of_bit;

  assign end_of_bit = (baud_q == CW'(BAUD_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_q <= '0;
      left_q <= '0;
      sh_q   <= '1;
      txd    <= 1'b1;
      busy   <= 1'b0;
    end else if (load && !busy) begin
      baud_q <= '0;
      left_q <= LW'(FRAME_BITS - 1);
      sh_q   <= {1'b1, par_bit, word};
      txd    <= 1'b0;
      busy   <= 1'b1;
    end else if (busy) begin
      if (end_of_bit) begin
        baud_q <= '0;
        if (left_q == '0) begin
          busy <= 1'b0;
        end else begin
          txd    <= sh_q[0];
          sh_q   <= {1'b1, sh_q[FRAME_BITS-2:1]};
          left_q <= left_q - 1'b1;
        end
      end else begin
        baud_q <= baud_q + 1'b1;
      end
    end
  end

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  assert_stop_high_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> txd);
  assert_no_load_busy_R9: assert property (@(posedge clk) disable iff (rst)
    busy && !end_of_bit |=> $stable(sh_q));
endmodule

// File: rtl/dws_top.sv
module dws_top
  import dws_pkg::*;
#(
  parameter int BAUD_DIV = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strobe_i,
  input  logic [NUM_DIGITS-1:0] digit_i,
  input  logic [3:0]            bcd_i,
  input  logic                  pos_i,
  input  logic                  ovr_i,
  input  logic                  und_i,
  input  logic                  par_sign_i,
  input  logic                  par_odd_i,
  output logic                  txd_o,
  output logic                  busy_o,
  output logic                  err_o
);
  logic [WORD_W-1:0] word;
  logic              odd_sel;
  logic              accept;
  logic              par_bit;
  par_cfg_t          cfg_live;

  assign accept   = strobe_i && !busy_o;
  assign cfg_live = '{sign_mode: par_sign_i, fixed_odd: par_odd_i, pos: pos_i};
  assign par_bit  = (^word) ^ odd_sel;

  dws_word_pack pack_i (
    .digit (digit_i),
    .bcd   (bcd_i),
    .pos   (pos_i),
    .ovr   (ovr_i),
    .und   (und_i),
    .word  (word)
  );

  dws_par_cfg cfg_i (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .is_msd  (digit_i[NUM_DIGITS-1]),
    .cfg_in  (cfg_live),
    .odd_sel (odd_sel)
  );

  dws_uart_tx #(.BAUD_DIV(BAUD_DIV)) tx_i (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .word    (word),
    .par_bit (par_bit),
    .txd     (txd_o),
    .busy    (busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                     err_o <= 1'b0;
    else if (strobe_i && busy_o) err_o <= 1'b1;
  end

  assert_err_sets_R9: assert property (@(posedge clk) disable iff (rst)
    strobe_i && busy_o |=> err_o);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);
  assert_busy_on_accept_R10: assert property (@(posedge clk) disable iff (rst)
    strobe_i && !busy_o |=> busy_o && !txd_o);
endmodule

// File: tb/dws_top_tb_top.sv
module dws_top_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_i = 1'b0;
  logic [4:0] digit_i = '0;
  logic [3:0] bcd_i = '0;
  logic       pos_i = 1'b0, ovr_i = 1'b0, und_i = 1'b0;
  logic       par_sign_i = 1'b0, par_odd_i = 1'b0;
  logic       txd_o, busy_o, err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit exp_err = 1'b0;
  bit h_sign = 1'b0, h_odd = 1'b0, h_pos = 1'b0;

  always #2 clk = ~clk;

  dws_top #(.BAUD_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .digit_i(digit_i), .bcd_i(bcd_i),
    .pos_i(pos_i), .ovr_i(ovr_i), .und_i(und_i), .par_sign_i(par_sign_i),
    .par_odd_i(par_odd_i), .txd_o(txd_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // d: digit number 1..5; collide: raise a second strobe three slots into the frame
  task automatic send(input int d, input logic [3:0] b, input bit p, input bit o, input bit u,
                      input bit ps, input bit po, input bit collide, input string req);
    logic [7:0]  w;
    logic [10:0] expf, got;
    bit          odd;
    bit          busy_ok;
    w[7:4] = (d == 5) ? 4'b0000 : 4'(1 << (d - 1));
    w[3:0] = (d == 5) ? {p, o, u, b[0]} : b;
    if (d == 5) begin h_sign = ps; h_odd = po; h_pos = p; end
    odd  = h_sign ? !h_pos : h_odd;
    expf = {1'b1, (^w) ^ odd, w, 1'b0};
    @(negedge clk);
    digit_i = 5'(1 << (d - 1)); bcd_i = b; pos_i = p; ovr_i = o; und_i = u;
    par_sign_i = ps; par_odd_i = po; strobe_i = 1'b1;
    @(negedge clk);
    strobe_i = 1'b0;
    got = '0;
    busy_ok = 1'b1;
    for (int c = 0; c <= 11 * DIV; c++) begin
      if (c % DIV == 1 && c / DIV < 11) got[c / DIV] = txd_o;
      if (busy_o !== (c < 11 * DIV)) busy_ok = 1'b0;
      if (collide && c == 3 * DIV) begin
        strobe_i = 1'b1; digit_i = 5'b00001; bcd_i = ~b; pos_i = !p;
        par_sign_i = !ps; par_odd_i = !po;
      end
      if (collide && c == 3 * DIV + 1) begin
        strobe_i = 1'b0;
        exp_err = 1'b1;
      end
      if (c < 11 * DIV) @(negedge clk);
    end
    check(req, 32'(got), 32'(expf));
    check("R10 busy window", 32'(busy_ok), 32'd1);
    check("R9 error flag", 32'(err_o), 32'(exp_err));
    check("R1 idle line", 32'(txd_o), 32'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset txd", 32'(txd_o), 32'd1);
    check("R1 reset busy", 32'(busy_o), 32'd0);
    check("R1 reset err", 32'(err_o), 32'd0);

    // R3 R5 R6 R7: all flag and bcd patterns of the top digit under three parity modes
    for (int m = 0; m < 3; m++)
      for (int f = 0; f < 128; f++)
        send(5, 4'(f), f[6], f[5], f[4], m == 2, m == 1, 1'b0, "R5 top-digit frame");

    // R2 R3 R4 R8: lower digits with parity inputs flipped from the sampled values
    for (int m = 0; m < 3; m++) begin
      send(5, 4'd1, m[0], 1'b0, 1'b0, m == 2, m == 1, 1'b0, "R3 burst head");
      for (int d = 4; d >= 1; d--)
        for (int b = 0; b < 10; b++)
          send(d, 4'(b), !m[0], 1'b1, 1'b1, m != 2, m != 1, 1'b0, "R8 held parity word");
    end
    for (int b = 10; b < 16; b++) send(2, 4'(b), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 data nibble");

    // R9: collision mid-frame, then a clean frame with the flag still set
    send(5, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R9 frame kept on collision");
    send(3, 4'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R9 frame after collision");
    send(1, 4'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 second collision");

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 err cleared by reset", 32'(err_o), 32'd0);
    exp_err = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule